// File: doc/BRIEF.md
# Five-Channel Capture/Compare/PWM Timer Array

This block holds one 16-bit free-running count that all five timing channels share. Each channel watches its own pin. It can timestamp that pin's edges, flag each rollover of the shared count, toggle an output when the count reaches a stored value, or produce an 8-bit pulse-width waveform. Each channel is configured on its own, so channels in different modes can work from the same count at the same time.

Software controls the block through a small write port. A write either sets a channel's control (mode, interrupt enable, flag clear) or loads that channel's 16-bit data register. A separate read select brings any channel's data register out, for example a captured timestamp. The count advances when three conditions hold: the run control is set, the count-enable strobe is high (this strobe stands in for a clock prescaler), and the hold input is low (hold models the idle state). A single interrupt line combines every channel whose flag and enable are both set.

Top module: `capcmp_array`

## Requirements
- R1: After reset, all of the following are zero: `cnt_value`, every data register, every flag, every pin output and `irq`.
- R2: On a clock edge where `run`, `cnt_en` and `hold` are 1, 1 and 0, the count goes up by one, and 16'hFFFF becomes 0. On any other edge the count keeps its value.
- R3: Pins pass through two synchronizer flops and then an edge detector. Suppose a pin changes between clock edges e and e+1. If that change matches the channel's capture mode, edge e+3 loads the data register with the count value held after edge e+2, and the same edge sets the flag.
- R4: Mode code 3'b001 captures on rising pin edges only. A falling edge leaves the data register and the flag unchanged.
- R5: Mode code 3'b010 captures on falling pin edges only. A rising edge leaves the data register and the flag unchanged.
- R6: Mode code 3'b011 captures on both rising and falling pin edges.
- R7: In mode code 3'b100, a channel sets its flag on the same edge at which the count wraps from 16'hFFFF to 0.
- R8: In mode code 3'b101, if the count equals the data register on an edge where the count advances, that edge inverts the channel's pin output and sets its flag.
- R9: In mode code 3'b110, the pin output is 0 while the count's low byte is below the channel's duty byte and 1 otherwise. Every low-byte wrap (the advance from xxFF) reloads the duty byte from data bits [15:8].
- R10: `irq` is 1 exactly when some channel has both its flag and its enable set.
- R11: A control write (`wr_sel`=0) sets the mode from `wr_data[2:0]` and the enable from `wr_data[3]`, and clears the compare toggle to 0. If `wr_data[4]`=1, it also clears the flag. If the channel has an event on the same edge, the event wins and the flag stays set.
- R12: Mode codes 3'b000 and 3'b111 are off. In those modes pin edges change neither the data register nor the flag, and the pin output stays 0.
- R13: A data write (`wr_sel`=1) loads `wr_data` into the data register of channel `wr_ch`. If a capture happens on the same edge, the capture wins. `rd_data` always shows the data register of channel `rd_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run control; the count stops while this is 0 |
| cnt_en | input | 1 | Count-enable strobe |
| hold | input | 1 | Idle hold; freezes the count |
| pin_in | input | 5 | Channel input pins (asynchronous) |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = control write, 1 = data write |
| wr_ch | input | 3 | Channel selected for the write |
| wr_data | input | 16 | Write value |
| rd_ch | input | 3 | Channel selected for `rd_data` |
| cnt_value | output | 16 | Shared count |
| rd_data | output | 16 | Data register of the selected channel |
| flags | output | 5 | Per-channel event flags |
| pin_out | output | 5 | Per-channel pin drive (compare toggle or PWM) |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded assertions check the following rules on every cycle:
- the count either steps by one or stays put;
- a capture loads exactly the previous count value;
- a compare hit flips the toggle;
- a flag stays set until it is cleared;
- a low-byte wrap reloads the duty byte;
- `irq` is never raised without a flag behind it.

Some behaviour can only be shown by the bench's scenarios:
- the exact three-edge latency from a pin change to its timestamp;
- the selectivity of each capture mode and of the off modes;
- the position of the compare toggle against the count;
- the high-time of the PWM waveform across a sweep of duty values;
- the rollover flag taken through the per-channel enable into `irq`.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  typedef enum logic [2:0] {
    MD_OFF      = 3'd0,
    MD_CAP_RISE = 3'd1,
    MD_CAP_FALL = 3'd2,
    MD_CAP_BOTH = 3'd3,
    MD_ROLL     = 3'd4,
    MD_CMP      = 3'd5,
    MD_PWM      = 3'd6,
    MD_OFF_ALT  = 3'd7
  } cc_mode_e;

  localparam int CTL_IE_BIT  = 3;
  localparam int CTL_CLR_BIT = 4;

endpackage

// File: rtl/capcmp_timebase.sv
module capcmp_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cnt_en,
  input  logic          hold,
  output logic [CW-1:0] cnt,
  output logic          adv,
  output logic          roll
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    adv   = run & cnt_en & ~hold;
    roll  = adv & (cnt_q == {CW{1'b1}});
    cnt_d = cnt_q;
    if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && cnt_en && !hold) |=> $stable(cnt_q)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en && !hold) |=> cnt_q == CW'($past(cnt_q) + 1'b1)); // R2

endmodule

// File: rtl/capcmp_edge.sv
module capcmp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic rise,
  output logic fall
);

  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_raw;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    rise = s2_q & ~prev_q;
    fall = ~s2_q & prev_q;
  end

endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          adv,
  input  logic          roll,
  input  logic          rise,
  input  logic          fall,
  input  logic          ctl_we,
  input  logic          data_we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] data_o,
  output logic          flag_o,
  output logic          ie_o,
  output logic          pin_o
);
  import capcmp_pkg::*;

  cc_mode_e      mode_q, mode_d;
  logic          ie_q, ie_d;
  logic          flag_q, flag_d;
  logic          tog_q, tog_d;
  logic [CW-1:0] data_q, data_d;
  logic [DW-1:0] duty_q, duty_d;
  logic          cap_hit, cmp_hit, roll_hit, evt, lo_wrap, pwm_lvl, clr_req;

  always_comb begin
    cap_hit  = ((mode_q == MD_CAP_RISE) & rise) |
               ((mode_q == MD_CAP_FALL) & fall) |
               ((mode_q == MD_CAP_BOTH) & (rise | fall));
    cmp_hit  = (mode_q == MD_CMP) & adv & (cnt == data_q);
    roll_hit = (mode_q == MD_ROLL) & roll;
    evt      = cap_hit | cmp_hit | roll_hit;
    lo_wrap  = adv & (cnt[DW-1:0] == {DW{1'b1}});
    clr_req  = ctl_we & wdata[CTL_CLR_BIT];
    pwm_lvl  = (cnt[DW-1:0] >= duty_q);
  end

  always_comb begin
    mode_d = mode_q;
    ie_d   = ie_q;
    if (ctl_we) begin
      mode_d = cc_mode_e'(wdata[2:0]);
      ie_d   = wdata[CTL_IE_BIT];
    end
    flag_d = flag_q;
    if (clr_req) flag_d = 1'b0;
    if (evt)     flag_d = 1'b1;
    data_d = data_q;
    if (data_we) data_d = wdata;
    if (cap_hit) data_d = cnt;
    tog_d = tog_q;
    if (cmp_hit) tog_d = ~tog_q;
    if (ctl_we)  tog_d = 1'b0;
    duty_d = duty_q;
    if (lo_wrap) duty_d = data_q[CW-1 -: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_OFF;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      data_q <= '0;
      tog_q  <= 1'b0;
      duty_q <= '0;
    end else begin
      mode_q <= mode_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
      data_q <= data_d;
      tog_q  <= tog_d;
      duty_q <= duty_d;
    end
  end

  always_comb begin
    case (mode_q)
      MD_PWM:  pin_o = pwm_lvl;
      MD_CMP:  pin_o = tog_q;
      default: pin_o = 1'b0;
    endcase
  end

  assign data_o = data_q;
  assign flag_o = flag_q;
  assign ie_o   = ie_q;

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> data_q == $past(cnt)); // R3

  AST_CMP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !ctl_we) |=> tog_q != $past(tog_q)); // R8

  AST_EVT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q); // R11

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q); // R11

  AST_DUTY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> duty_q == $past(data_q[CW-1 -: DW])); // R9

endmodule

// File: rtl/capcmp_array.sv
module capcmp_array #(
  parameter int NCH = 5,
  parameter int CW  = 16,
  parameter int DW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           cnt_en,
  input  logic           hold,
  input  logic [NCH-1:0] pin_in,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [CHW-1:0] wr_ch,
  input  logic [CW-1:0]  wr_data,
  input  logic [CHW-1:0] rd_ch,
  output logic [CW-1:0]  cnt_value,
  output logic [CW-1:0]  rd_data,
  output logic [NCH-1:0] flags,
  output logic [NCH-1:0] pin_out,
  output logic           irq
);

  logic [CW-1:0]  cnt;
  logic           adv, roll;
  logic [NCH-1:0] ies;
  logic [CW-1:0]  ch_data [NCH];

  capcmp_timebase #(.CW(CW)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .cnt_en (cnt_en),
    .hold   (hold),
    .cnt    (cnt),
    .adv    (adv),
    .roll   (roll)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic rise, fall, ctl_we, data_we;

    assign ctl_we  = wr_en & ~wr_sel & (wr_ch == CHW'(i));
    assign data_we = wr_en &  wr_sel & (wr_ch == CHW'(i));

    capcmp_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_raw (pin_in[i]),
      .rise    (rise),
      .fall    (fall)
    );

    capcmp_channel #(.CW(CW), .DW(DW)) u_channel (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnt),
      .adv     (adv),
      .roll    (roll),
      .rise    (rise),
      .fall    (fall),
      .ctl_we  (ctl_we),
      .data_we (data_we),
      .wdata   (wr_data),
      .data_o  (ch_data[i]),
      .flag_o  (flags[i]),
      .ie_o    (ies[i]),
      .pin_o   (pin_out[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_ch == CHW'(i)) rd_data = ch_data[i];
    end
  end

  assign cnt_value = cnt;
  assign irq       = |(flags & ies);

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0)); // R10

endmodule

// File: tb/capcmp_array_bench.sv
module capcmp_array_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, cnt_en, hold;
  logic [4:0]  pin_in;
  logic        wr_en, wr_sel;
  logic [2:0]  wr_ch, rd_ch;
  logic [15:0] wr_data;
  logic [15:0] cnt_value, rd_data;
  logic [4:0]  flags, pin_out;
  logic        irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  capcmp_array u_capcmp_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cnt_en    (cnt_en),
    .hold      (hold),
    .pin_in    (pin_in),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_ch     (wr_ch),
    .wr_data   (wr_data),
    .rd_ch     (rd_ch),
    .cnt_value (cnt_value),
    .rd_data   (rd_data),
    .flags     (flags),
    .pin_out   (pin_out),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input int ch, input logic [2:0] md, input logic ie, input logic clr);
    wr_en = 1'b1; wr_sel = 1'b0; wr_ch = 3'(ch);
    wr_data = {11'd0, clr, ie, md};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic dat(input int ch, input logic [15:0] v);
    wr_en = 1'b1; wr_sel = 1'b1; wr_ch = 3'(ch); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, output logic [15:0] v);
    rd_ch = 3'(ch);
    #1;
    v = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c0, c1, d0, d1, d2, d3, d4, tgt;
    rst_n = 1'b0; run = 1'b0; cnt_en = 1'b0; hold = 1'b0; pin_in = '0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_ch = '0; wr_data = '0; rd_ch = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cnt", cnt_value, 0);
    check("R1 flags", flags, 0);
    check("R1 pins", pin_out, 0);
    check("R1 irq", irq, 0);
    for (int i = 0; i < 5; i++) begin rd(i, v); check("R1 data", v, 0); end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 counting and freezing
    run = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      v = cnt_value; @(negedge clk);
      check("R2 step", cnt_value, 16'(v + 1));
    end
    hold = 1'b1; v = cnt_value; repeat (3) @(negedge clk);
    check("R2 hold", cnt_value, v);
    hold = 1'b0; run = 1'b0; repeat (3) @(negedge clk);
    check("R2 run off", cnt_value, v);
    run = 1'b1; cnt_en = 1'b0; repeat (3) @(negedge clk);
    check("R2 cnt_en off", cnt_value, v);
    cnt_en = 1'b1; @(negedge clk);
    check("R2 resume", cnt_value, 16'(v + 1));

    // R3-R6, R12: capture modes over several gaps; ch3/ch4 off
    ctl(0, 3'b001, 1'b0, 1'b1);
    ctl(1, 3'b010, 1'b0, 1'b1);
    ctl(2, 3'b011, 1'b0, 1'b1);
    ctl(4, 3'b111, 1'b0, 1'b1);
    d1 = 16'h0;
    for (int gap = 1; gap <= 9; gap += 2) begin
      ctl(0, 3'b001, 1'b0, 1'b1); ctl(1, 3'b010, 1'b0, 1'b1); ctl(2, 3'b011, 1'b0, 1'b1);
      c0 = cnt_value; pin_in = 5'b11111;
      repeat (4) @(negedge clk);
      rd(0, d0); check("R4 rise capture", d0, 16'(c0 + 2));
      rd(1, v);  check("R5 rise ignored", v, d1);
      rd(2, d2); check("R6 both rise", d2, 16'(c0 + 2));
      check("R3 flags on rise", flags, 5'b00101);
      repeat (gap) @(negedge clk);
      ctl(0, 3'b001, 1'b0, 1'b1); ctl(1, 3'b010, 1'b0, 1'b1); ctl(2, 3'b011, 1'b0, 1'b1);
      c1 = cnt_value; pin_in = 5'b00000;
      repeat (4) @(negedge clk);
      rd(0, v);  check("R4 fall ignored", v, d0);
      rd(1, d1); check("R5 fall capture", d1, 16'(c1 + 2));
      rd(2, v);  check("R6 both fall", v, 16'(c1 + 2));
      check("R3 flags on fall", flags, 5'b00110);
      rd(3, d3); check("R12 off data ch3", d3, 0);
      rd(4, d4); check("R12 off data ch4", d4, 0);
      check("R12 off pins", pin_out, 0);
      repeat (gap) @(negedge clk);
    end
    // R13 data write and readback
    dat(3, 16'hA55A); rd(3, v); check("R13 data write", v, 16'hA55A);
    rd(0, v); check("R13 other channel kept", v, d0);

    // R8 compare toggle, R10 irq, R11 control write
    ctl(0, 3'b000, 1'b0, 1'b1); ctl(1, 3'b000, 1'b0, 1'b1); ctl(2, 3'b000, 1'b0, 1'b1);
    for (int k = 0; k < 2; k++) begin
      tgt = 16'(cnt_value + 40 + 57 * k);
      dat(3, tgt);
      ctl(3, 3'b101, 1'b1, 1'b1);
      while (cnt_value != tgt) @(negedge clk);
      check("R8 before match pin", pin_out[3], 0);
      check("R8 before match flag", flags[3], 0);
      @(negedge clk);
      check("R8 after match pin", pin_out[3], 1);
      check("R8 after match flag", flags[3], 1);
      check("R10 irq raised", irq, 1);
      ctl(3, 3'b101, 1'b1, 1'b1);
      check("R11 clear flag", flags[3], 0);
      check("R11 toggle reset", pin_out[3], 0);
      check("R10 irq dropped", irq, 0);
    end
    ctl(3, 3'b000, 1'b0, 1'b1);

    // R9 PWM sweep
    ctl(4, 3'b110, 1'b0, 1'b1);
    for (int t = 0; t < 7; t++) begin
      int duty, highs, first;
      duty = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 64 : (t == 3) ? 127 :
             (t == 4) ? 128 : (t == 5) ? 200 : 255;
      dat(4, {8'(duty), 8'h3C});
      @(negedge clk);
      while (cnt_value[7:0] != 8'h00) @(negedge clk);
      highs = 0; first = -1;
      for (int s = 0; s < 256; s++) begin
        if (pin_out[4]) begin
          highs++;
          if (first < 0) first = s;
        end
        @(negedge clk);
      end
      check("R9 pwm high count", highs, 256 - duty);
      check("R9 pwm first high", first, duty);
    end
    ctl(4, 3'b000, 1'b0, 1'b1);

    // R7 rollover flag, R10 enable gating
    ctl(0, 3'b100, 1'b1, 1'b1);
    ctl(1, 3'b100, 1'b0, 1'b1);
    while (cnt_value != 16'hFFFF) @(negedge clk);
    check("R7 before wrap", flags, 0);
    check("R10 no irq before wrap", irq, 0);
    @(negedge clk);
    check("R7 wrap count", cnt_value, 0);
    check("R7 wrap flags", flags, 5'b00011);
    check("R10 irq from enabled", irq, 1);
    ctl(0, 3'b100, 1'b1, 1'b1);
    check("R10 disabled flag no irq", irq, 0);
    check("R10 disabled flag kept", flags, 5'b00010);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule